// File: doc/BRIEF.md
# Flash Page DMA Setup Sequencer

This block sits between a host register write port and a flash-page transfer engine. Software sets up one transfer by writing four command/data word pairs: a command word, then its data word. The block checks every word as it arrives: the fixed prefix fields, the pair selector that names each pair, the reserved bits, the alignment of the host buffer address and the burst length. Only a series that passes every check reaches the engine. Any fault raises a one-cycle error pulse with a cause code. The block then drops the partial setup and waits for pair 1 again.

When the fourth pair is accepted, the block latches a transfer descriptor and pulses `xfer_start`. It then stays busy, refusing further writes, until the engine reports `xfer_done`. At that point a completion status bit is set if the setup asked for an interrupt. Software clears the bit by writing one to `irq_clr`. The number of page-address bits, PG_W, is ceil(log2(PAGES_PER_BLK)). This gives 5, 6, 7 or 8 for 32, 64, 128 or 256 pages per block, and 9 for both 384 and 512.

Top module: `dps_pair_seq`

## Requirements
- R1: A command word must hold 0x08 in bits 31:24, and a data word must hold 0x00002 in bits 31:12. Otherwise, one cycle after the write, `err_valid` pulses with `err_code`=1 (field error) and the setup restarts at pair 1.
- R2: Bits 11:8 of each data word select the pair: 0 or 1 means pair 1, and 2, 3 and 4 mean pairs 2, 3 and 4. Pairs must arrive in the order 1, 2, 3, 4. A selector from 0 to 4 that does not match the expected pair gives `err_code`=2 (order error). A selector above 4 gives code 1. After either error, the setup restarts at pair 1.
- R3: In the pair 1 command, bits 23:PG_W give `desc_block` and bits PG_W-1:0 give `desc_page`. With the default of 64 pages per block, PG_W is 6.
- R4: In the pair 1 data word, bit 8 gives `desc_write` (selector 0 means read, 1 means write), and bits 7:0 give `desc_npages`.
- R5: Bits 23:8 of the pair 2 command form `desc_addr[31:16]`, and bits 23:8 of the pair 3 command form `desc_addr[15:0]`. If the pair 3 command has bit 9 or bit 8 set, the address is not 32-bit aligned, and the block reports `err_code`=3.
- R6: Bits 15:8 of the pair 4 command give the burst length, and bit 16 gives the interrupt enable. A burst length other than 4, 16, 32 or 64 gives `err_code`=4.
- R7: `xfer_start` is high for exactly one cycle, in the cycle after the accepted pair 4 data write. All descriptor outputs take their new values in that same cycle and hold them until the next start.
- R8: `busy` rises together with `xfer_start` and falls in the cycle after `xfer_done`. While `busy` is high, writes are refused with no error and no change in state. `xfer_done` has no effect while `busy` is low.
- R9: In the cycle after `xfer_done` ends a transfer, `irq_status` is 1 if the interrupt enable was set. It stays 1 until `irq_clr` is high. If a completion and a clear arrive together, the completion wins.
- R10: Bits 7:0 of the pair 2 and pair 3 commands must be zero, and so must bits 23:17 and 7:0 of the pair 4 command. A violation gives `err_code`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host word write strobe |
| wr_word | input | 32 | Host word; command and data words alternate |
| xfer_done | input | 1 | Transfer engine finished |
| irq_clr | input | 1 | Write-one-to-clear for irq_status |
| busy | output | 1 | Transfer running; writes refused |
| err_valid | output | 1 | One-cycle error pulse |
| err_code | output | 3 | Cause of the last error (1 field, 2 order, 3 align, 4 burst) |
| xfer_start | output | 1 | One-cycle start pulse |
| desc_block | output | 24-PG_W | Block address |
| desc_page | output | PG_W | Page address |
| desc_write | output | 1 | 1 = write, 0 = read |
| desc_npages | output | 8 | Page count |
| desc_addr | output | 32 | Host buffer address |
| desc_burst | output | 8 | Burst length in bytes |
| desc_irq_en | output | 1 | Interrupt on completion |
| irq_status | output | 1 | Completion status bit |

## Verification
Random legal setups vary the block, page, direction, page count, aligned address, legal burst and interrupt enable. These runs show that each descriptor field comes from the right bits, and they catch a wrong block/page split. Directed cases each break one rule: a bad prefix, a pair sent early, a reserved bit, a misaligned address and an illegal burst. Each case must give its own cause code, and a clean series sent after the fault must still start. Further cases write while busy, raise done while idle, and assert completion and clear in the same cycle. These show that refused input leaves no trace and that a completion wins over a clear.

// File: rtl/dps_pkg.sv
package dps_pkg;
  typedef enum logic [2:0] {
    ERR_NONE  = 3'd0,
    ERR_FIELD = 3'd1,
    ERR_ORDER = 3'd2,
    ERR_ALIGN = 3'd3,
    ERR_BURST = 3'd4
  } err_e;

  typedef enum logic {PH_CMD = 1'b0, PH_DATA = 1'b1} phase_e;

  localparam logic [7:0]  CMD_PREFIX  = 8'h08;
  localparam logic [19:0] DATA_PREFIX = 20'h00002;

  function automatic logic burst_legal(input logic [7:0] b);
    return (b == 8'd4) || (b == 8'd16) || (b == 8'd32) || (b == 8'd64);
  endfunction
endpackage

// File: rtl/dps_pair_check.sv
module dps_pair_check
  import dps_pkg::*;
(
  input  logic [1:0]  exp_pair,   // 0..3 for pairs 1..4
  input  logic [6:0]  cmd_resv,   // command bits 23:17
  input  logic [15:0] cmd_low,    // command bits 15:0
  input  logic [23:0] data_hi,    // data bits 31:8
  output err_e        verdict
);
  logic [3:0] sel;
  logic [3:0] want;
  assign sel  = data_hi[3:0];
  assign want = {2'b00, exp_pair} + 4'd1;

  always_comb begin
    verdict = ERR_NONE;
    if (data_hi[23:4] != DATA_PREFIX) begin
      verdict = ERR_FIELD;
    end else if (exp_pair == 2'd0) begin
      if (sel > 4'd1) verdict = (sel <= 4'd4) ? ERR_ORDER : ERR_FIELD;
    end else if (sel != want) begin
      verdict = (sel <= 4'd4) ? ERR_ORDER : ERR_FIELD;
    end else begin
      unique case (exp_pair)
        2'd1: if (cmd_low[7:0] != 8'h00) verdict = ERR_FIELD;
        2'd2: begin
          if (cmd_low[7:0] != 8'h00)      verdict = ERR_FIELD;
          else if (cmd_low[9:8] != 2'b00) verdict = ERR_ALIGN;
        end
        default: begin
          if (cmd_resv != 7'h00 || cmd_low[7:0] != 8'h00) verdict = ERR_FIELD;
          else if (!burst_legal(cmd_low[15:8]))            verdict = ERR_BURST;
        end
      endcase
    end
  end
endmodule

// File: rtl/dps_seq_ctrl.sv
module dps_seq_ctrl
  import dps_pkg::*;
#(
  parameter int PG_W  = 6,
  parameter int BLK_W = 24 - PG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [31:0]      wr_word,
  input  logic             xfer_done,
  output logic             busy,
  output logic             err_valid,
  output logic [2:0]       err_code,
  output logic             xfer_start,
  output logic [BLK_W-1:0] desc_block,
  output logic [PG_W-1:0]  desc_page,
  output logic             desc_write,
  output logic [7:0]       desc_npages,
  output logic [31:0]      desc_addr,
  output logic [7:0]       desc_burst,
  output logic             desc_irq_en
);
  phase_e           phase;
  logic [1:0]       exp_pair;
  logic [23:0]      cmd_hold;
  logic [BLK_W-1:0] st_block;
  logic [PG_W-1:0]  st_page;
  logic             st_write;
  logic [7:0]       st_npages;
  logic [15:0]      st_addr_hi;
  logic [15:0]      st_addr_lo;
  err_e             verdict;
  logic             accept;

  assign accept = wr_en && !busy;

  dps_pair_check u_check (
    .exp_pair (exp_pair),
    .cmd_resv (cmd_hold[23:17]),
    .cmd_low  (cmd_hold[15:0]),
    .data_hi  (wr_word[31:8]),
    .verdict  (verdict)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= PH_CMD;
      exp_pair    <= 2'd0;
      cmd_hold    <= '0;
      busy        <= 1'b0;
      err_valid   <= 1'b0;
      err_code    <= ERR_NONE;
      xfer_start  <= 1'b0;
      st_block    <= '0;
      st_page     <= '0;
      st_write    <= 1'b0;
      st_npages   <= '0;
      st_addr_hi  <= '0;
      st_addr_lo  <= '0;
      desc_block  <= '0;
      desc_page   <= '0;
      desc_write  <= 1'b0;
      desc_npages <= '0;
      desc_addr   <= '0;
      desc_burst  <= '0;
      desc_irq_en <= 1'b0;
    end else begin
      xfer_start <= 1'b0;
      err_valid  <= 1'b0;
      if (busy && xfer_done) busy <= 1'b0;
      if (accept) begin
        if (phase == PH_CMD) begin
          if (wr_word[31:24] != CMD_PREFIX) begin
            err_valid <= 1'b1;
            err_code  <= ERR_FIELD;
            exp_pair  <= 2'd0;
          end else begin
            cmd_hold <= wr_word[23:0];
            phase    <= PH_DATA;
          end
        end else begin
          phase <= PH_CMD;
          if (verdict != ERR_NONE) begin
            err_valid <= 1'b1;
            err_code  <= verdict;
            exp_pair  <= 2'd0;
          end else begin
            unique case (exp_pair)
              2'd0: begin
                st_block  <= cmd_hold[23:PG_W];
                st_page   <= cmd_hold[PG_W-1:0];
                st_write  <= wr_word[8];
                st_npages <= wr_word[7:0];
                exp_pair  <= 2'd1;
              end
              2'd1: begin
                st_addr_hi <= cmd_hold[23:8];
                exp_pair   <= 2'd2;
              end
              2'd2: begin
                st_addr_lo <= cmd_hold[23:8];
                exp_pair   <= 2'd3;
              end
              default: begin
                desc_block  <= st_block;
                desc_page   <= st_page;
                desc_write  <= st_write;
                desc_npages <= st_npages;
                desc_addr   <= {st_addr_hi, st_addr_lo};
                desc_burst  <= cmd_hold[15:8];
                desc_irq_en <= cmd_hold[16];
                xfer_start  <= 1'b1;
                busy        <= 1'b1;
                exp_pair    <= 2'd0;
              end
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/dps_irq_status.sv
module dps_irq_status (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic clr,
  output logic irq_status
);
  always_ff @(posedge clk) begin
    if (rst)          irq_status <= 1'b0;
    else if (set_evt) irq_status <= 1'b1;
    else if (clr)     irq_status <= 1'b0;
  end
endmodule

// File: rtl/dps_pair_seq.sv
module dps_pair_seq #(
  parameter int PAGES_PER_BLK = 64,
  localparam int PG_W  = $clog2(PAGES_PER_BLK),
  localparam int BLK_W = 24 - PG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [31:0]      wr_word,
  input  logic             xfer_done,
  input  logic             irq_clr,
  output logic             busy,
  output logic             err_valid,
  output logic [2:0]       err_code,
  output logic             xfer_start,
  output logic [BLK_W-1:0] desc_block,
  output logic [PG_W-1:0]  desc_page,
  output logic             desc_write,
  output logic [7:0]       desc_npages,
  output logic [31:0]      desc_addr,
  output logic [7:0]       desc_burst,
  output logic             desc_irq_en,
  output logic             irq_status
);
  logic done_evt;

  dps_seq_ctrl #(.PG_W(PG_W), .BLK_W(BLK_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_word     (wr_word),
    .xfer_done   (xfer_done),
    .busy        (busy),
    .err_valid   (err_valid),
    .err_code    (err_code),
    .xfer_start  (xfer_start),
    .desc_block  (desc_block),
    .desc_page   (desc_page),
    .desc_write  (desc_write),
    .desc_npages (desc_npages),
    .desc_addr   (desc_addr),
    .desc_burst  (desc_burst),
    .desc_irq_en (desc_irq_en)
  );

  assign done_evt = busy && xfer_done && desc_irq_en;

  dps_irq_status u_irq (
    .clk        (clk),
    .rst        (rst),
    .set_evt    (done_evt),
    .clr        (irq_clr),
    .irq_status (irq_status)
  );
endmodule

// File: rtl/dps_pair_seq_chk.sv
module dps_pair_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       err_valid,
  input logic [2:0] err_code,
  input logic       xfer_start,
  input logic       xfer_done,
  input logic       irq_clr,
  input logic       irq_en,
  input logic       irq_status,
  input logic [1:0] addr_lsb,
  input logic [7:0] burst
);
  AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    err_valid |-> (err_code != 3'd0)); // R1
  AST_START_NO_ERR: assert property (@(posedge clk) disable iff (rst)
    xfer_start |-> !err_valid); // R2
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    xfer_start |-> (addr_lsb == 2'b00)); // R5
  AST_BURST_LEGAL: assert property (@(posedge clk) disable iff (rst)
    xfer_start |-> (burst == 8'd4 || burst == 8'd16 || burst == 8'd32 || burst == 8'd64)); // R6
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    xfer_start |=> !xfer_start); // R7
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    xfer_start |-> busy); // R8
  AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (rst)
    busy |=> !err_valid); // R8
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (rst)
    (busy && xfer_done && irq_en) |=> irq_status); // R9
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (irq_status && !irq_clr) |=> irq_status); // R9
endmodule

bind dps_pair_seq dps_pair_seq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .err_valid  (err_valid),
  .err_code   (err_code),
  .xfer_start (xfer_start),
  .xfer_done  (xfer_done),
  .irq_clr    (irq_clr),
  .irq_en     (desc_irq_en),
  .irq_status (irq_status),
  .addr_lsb   (desc_addr[1:0]),
  .burst      (desc_burst)
);

// File: tb/dps_pair_seq_tb.sv
module dps_pair_seq_tb;
  localparam int PG = 6;
  localparam int BW = 24 - PG;

  logic          clk = 1'b0;
  logic          rst;
  logic          wr_en = 1'b0;
  logic [31:0]   wr_word = '0;
  logic          xfer_done = 1'b0;
  logic          irq_clr = 1'b0;
  logic          busy, err_valid, xfer_start, desc_write, desc_irq_en, irq_status;
  logic [2:0]    err_code;
  logic [BW-1:0] desc_block;
  logic [PG-1:0] desc_page;
  logic [7:0]    desc_npages, desc_burst;
  logic [31:0]   desc_addr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dps_pair_seq #(.PAGES_PER_BLK(64)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_word(wr_word),
    .xfer_done(xfer_done), .irq_clr(irq_clr), .busy(busy),
    .err_valid(err_valid), .err_code(err_code), .xfer_start(xfer_start),
    .desc_block(desc_block), .desc_page(desc_page), .desc_write(desc_write),
    .desc_npages(desc_npages), .desc_addr(desc_addr), .desc_burst(desc_burst),
    .desc_irq_en(desc_irq_en), .irq_status(irq_status)
  );

  function automatic logic [31:0] mk_cmd(input logic [23:0] f);
    return {8'h08, f};
  endfunction
  function automatic logic [31:0] mk_data(input logic [3:0] sel, input logic [7:0] lo);
    return {16'h0000, 4'h2, sel, lo};
  endfunction
  function automatic logic [7:0] pick_burst(input int k);
    case (k % 4)
      0: return 8'd4;
      1: return 8'd16;
      2: return 8'd32;
      default: return 8'd64;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] w);
    @(negedge clk);
    wr_en = 1'b1; wr_word = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pair(input logic [31:0] c, input logic [31:0] d);
    wr(c);
    wr(d);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic pulse_done();
    @(negedge clk); xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
  endtask

  // Sends a full legal setup; leaves the bench at the negedge after pair 4 data.
  task automatic full_setup(input logic [BW-1:0] blk, input logic [PG-1:0] pg,
                            input logic dir, input logic [7:0] np,
                            input logic [31:0] addr, input logic [7:0] bl,
                            input logic ie);
    pair(mk_cmd({blk, pg}), mk_data({3'b000, dir}, np));
    pair(mk_cmd({addr[31:16], 8'h00}), mk_data(4'h2, 8'h00));
    pair(mk_cmd({addr[15:0], 8'h00}), mk_data(4'h3, 8'h00));
    pair(mk_cmd({7'h00, ie, bl, 8'h00}), mk_data(4'h4, 8'h00));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [BW-1:0] blk;
    logic [PG-1:0] pg;
    logic dir, ie;
    logic [7:0] np, bl;
    logic [31:0] addr;
    void'($urandom(32'd20240611));

    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 reset busy", busy, 0);
    chk("R7 reset start", xfer_start, 0);
    chk("R9 reset irq", irq_status, 0);
    chk("R1 reset err", err_valid, 0);

    // R8: done while idle has no effect
    pulse_done();
    chk("R8 idle done busy", busy, 0);
    chk("R8 idle done irq", irq_status, 0);

    for (int i = 0; i < 24; i++) begin
      blk  = BW'($urandom);
      pg   = PG'($urandom);
      dir  = 1'($urandom);
      np   = 8'($urandom);
      addr = $urandom & 32'hFFFF_FFFC;
      bl   = pick_burst(int'($urandom % 4));
      ie   = 1'($urandom);
      full_setup(blk, pg, dir, np, addr, bl, ie);
      chk("R7 start pulse", xfer_start, 1);
      chk("R8 busy rise", busy, 1);
      chk("R3 block", desc_block, blk);
      chk("R3 page", desc_page, pg);
      chk("R4 direction", desc_write, dir);
      chk("R4 npages", desc_npages, np);
      chk("R5 address", desc_addr, addr);
      chk("R6 burst", desc_burst, bl);
      chk("R6 irq enable", desc_irq_en, ie);
      @(negedge clk);
      chk("R7 start drop", xfer_start, 0);
      // R8: write while busy is refused
      wr(mk_cmd(24'hFFFFFF));
      chk("R8 busy no err", err_valid, 0);
      wr(mk_data(4'h9, 8'h00));
      chk("R8 busy no err data", err_valid, 0);
      chk("R8 busy desc hold", desc_addr, addr);
      pulse_done();
      chk("R8 busy fall", busy, 0);
      chk("R9 irq after done", irq_status, ie);
      @(negedge clk); irq_clr = 1'b1;
      @(negedge clk); irq_clr = 1'b0;
      chk("R9 irq cleared", irq_status, 0);
    end

    // R1: bad command prefix
    wr(32'h18000000);
    chk("R1 cmd prefix err", err_valid, 1);
    chk("R1 cmd prefix code", err_code, 1);
    // R1: bad data prefix
    pair(mk_cmd(24'h000001), 32'h00013000);
    chk("R1 data prefix code", {err_valid, err_code}, {1'b1, 3'd1});
    // R2: pair 2 first
    pair(mk_cmd(24'h123400), mk_data(4'h2, 8'h00));
    chk("R2 early pair code", {err_valid, err_code}, {1'b1, 3'd2});
    // R2: selector above 4
    pair(mk_cmd(24'h000001), mk_data(4'h7, 8'h00));
    chk("R2 bad selector code", {err_valid, err_code}, {1'b1, 3'd1});
    // R2: pair 1 then pair 3 skips pair 2
    pair(mk_cmd(24'h000001), mk_data(4'h0, 8'h01));
    chk("R2 pair1 ok", err_valid, 0);
    pair(mk_cmd(24'h000100), mk_data(4'h3, 8'h00));
    chk("R2 skipped pair code", {err_valid, err_code}, {1'b1, 3'd2});
    // R2: setup discarded, so pair 2 now is out of order
    pair(mk_cmd(24'h000100), mk_data(4'h2, 8'h00));
    chk("R2 discard restart", {err_valid, err_code}, {1'b1, 3'd2});
    // R5: misaligned low address
    pair(mk_cmd(24'h000001), mk_data(4'h1, 8'h02));
    pair(mk_cmd(24'hABCD00), mk_data(4'h2, 8'h00));
    pair(mk_cmd(24'h000200), mk_data(4'h3, 8'h00));
    chk("R5 align code", {err_valid, err_code}, {1'b1, 3'd3});
    // R10: reserved bits of pair 2
    pair(mk_cmd(24'h000001), mk_data(4'h1, 8'h02));
    pair(mk_cmd(24'hABCD01), mk_data(4'h2, 8'h00));
    chk("R10 pair2 reserved", {err_valid, err_code}, {1'b1, 3'd1});
    // R6: illegal burst 8
    pair(mk_cmd(24'h000001), mk_data(4'h1, 8'h02));
    pair(mk_cmd(24'h000000), mk_data(4'h2, 8'h00));
    pair(mk_cmd(24'h001000), mk_data(4'h3, 8'h00));
    pair(mk_cmd(24'h000800), mk_data(4'h4, 8'h00));
    chk("R6 burst code", {err_valid, err_code}, {1'b1, 3'd4});
    chk("R6 no start", xfer_start, 0);
    // R10: reserved bit 17 of pair 4
    pair(mk_cmd(24'h000001), mk_data(4'h1, 8'h02));
    pair(mk_cmd(24'h000000), mk_data(4'h2, 8'h00));
    pair(mk_cmd(24'h001000), mk_data(4'h3, 8'h00));
    pair(mk_cmd(24'h021000), mk_data(4'h4, 8'h00));
    chk("R10 pair4 reserved", {err_valid, err_code}, {1'b1, 3'd1});
    // R7: clean series after errors still starts
    full_setup(18'h3FFFF, 6'h3F, 1'b0, 8'hFF, 32'hFFFF_FFFC, 8'd64, 1'b1);
    chk("R7 start after errors", xfer_start, 1);
    chk("R3 block max", desc_block, 18'h3FFFF);
    chk("R4 read dir", desc_write, 0);
    // R9: completion and clear together, set wins
    @(negedge clk); xfer_done = 1'b1; irq_clr = 1'b1;
    @(negedge clk); xfer_done = 1'b0; irq_clr = 1'b0;
    chk("R9 set beats clear", irq_status, 1);
    @(negedge clk);
    chk("R9 irq holds", irq_status, 1);
    finish_run();
  end
endmodule